// File: doc/BRIEF.md
# Pointer-Based Indirect Register Access Unit

This block is the host-side register front end of a peripheral with two register banks. One bank serves two serial channels, A and B, with a full register set each. The other bank serves a DMA section. Two chip-level select lines pick the target of each access. A strap input, sampled while reset is asserted, fixes one of two bus modes until the next reset.

In indirect mode, the host reaches registers through a pointer. The first write to a bank's register 0 loads that bank's pointer. The next access, read or write, goes to the register the pointer selects, and the pointer then returns to zero by itself. The serial bank and the DMA bank each keep their own pointer. In direct mode there is no pointer. The host places an address on the shared address/data bus and pulses an address strobe low. The data phase that follows uses the latched address, decoded with a shift-left or shift-right mapping that each bank selects on its own. The block holds the register storage and returns read data one cycle after a read strobe.

Each pointer is managed by a two-state machine. PTR_IDLE means the pointer is zero and register 0 is addressed. PTR_ARMED means a nonzero pointer is loaded. The LOAD transition, PTR_IDLE to PTR_ARMED, fires on a write of a nonzero pointer value to register 0 of the bank in indirect mode. The USE transition, PTR_ARMED to PTR_IDLE, fires on any access to that bank and clears the pointer.

Top module: `iaccess_top`

## Requirements
- R1: `sel_a0`=1 with `sel_a1`=1 selects serial channel A. `sel_a0`=1 with `sel_a1`=0 selects serial channel B. `sel_a0`=0 selects the DMA bank, and `sel_a1` is ignored.
- R2: In indirect mode, a write to serial register 0 loads the serial pointer. Data bits 2:0 give pointer bits 2:0. Pointer bit 3 is set only when data bits 5:3 equal 3'b001, the point-high command.
- R3: In indirect mode, the access that follows a pointer load targets the pointed register, whether it is a read or a write. After it, the pointer is zero, so the next write goes to register 0 and the next read returns status register 0.
- R4: In indirect mode, a write to DMA register 0 loads the 5-bit DMA pointer from data bits 4:0. Accesses to either bank leave the other bank's pointer unchanged.
- R5: In direct mode, `bus_data` is latched on the cycle `as_n` falls. The register index is latched bits 5:1 in shift-left mode and bits 4:0 in shift-right mode. No pointer is used.
- R6: In direct mode, a write to serial register 0 sets the serial shift mode from data bits 1:0: 2'b01 selects left, 2'b10 selects right, and other codes leave it unchanged. Bit 0 of DMA register 1 sets the DMA shift mode (1 = left).
- R7: Reset clears both pointers, all storage and `rd_valid`, and selects shift-right mode for both banks. The mode strap is sampled while `rst_n` is low: 1 selects direct mode.
- R8: Serial indices of 12 or more and DMA indices of 8 or more are unimplemented. A read of one returns 0, and a write to one changes no register. Either access still clears the pointer.
- R9: `rd_valid` is high, with `rd_data`, in exactly the cycle after a cycle with `rd_en` high and `wr_en` low.
- R10: A read of serial register 0 returns {6'b0, serial shift-left flag, channel-is-A}. A read of DMA register 0 returns {3'b0, DMA pointer}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_strap | input | 1 | Bus mode strap, sampled during reset (1 = direct) |
| sel_a0 | input | 1 | Bank select: 1 = serial, 0 = DMA |
| sel_a1 | input | 1 | Channel select for the serial bank: 1 = A, 0 = B |
| as_n | input | 1 | Address strobe, active low, used in direct mode |
| bus_data | input | 8 | Shared address/data input |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |

## Verification
The hardest case to reach is a pointer that survives accesses to the other bank. The bench loads the serial pointer and then runs a complete DMA pointer-and-data pair before it issues the serial read. The read must land on the register named before the detour. The point-high path is told apart from the low-bit path by reading a never-written register that has the same low three bits. The shift-mode cases use one raw strobe address that maps to two different indices, once before and once after the mode change.

// File: rtl/iaccess_pkg.sv
package iaccess_pkg;
    localparam int DATA_W   = 8;
    localparam int IDX_W    = 5;
    localparam int SER_PW   = 4;
    localparam int DMA_PW   = 5;
    localparam int DMA_CFG  = 1;
    localparam logic [2:0] CMD_PT_HIGH = 3'b001;

    typedef enum logic {
        PTR_IDLE  = 1'b0,
        PTR_ARMED = 1'b1
    } ptr_state_e;
endpackage

// File: rtl/iaccess_ptr_fsm.sv
module iaccess_ptr_fsm
    import iaccess_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [PW-1:0] load_val_i,
    input  logic          use_i,
    output logic [PW-1:0] ptr_o,
    output logic          armed_o
);
    ptr_state_e state_q, state_d;
    logic [PW-1:0] ptr_q, ptr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PTR_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            PTR_IDLE: begin
                if (load_i && load_val_i != '0) begin
                    state_d = PTR_ARMED;
                    ptr_d   = load_val_i;
                end
            end
            PTR_ARMED: begin
                if (use_i) begin
                    state_d = PTR_IDLE;
                    ptr_d   = '0;
                end
            end
            default: begin
                state_d = PTR_IDLE;
                ptr_d   = '0;
            end
        endcase
    end

    assign ptr_o   = ptr_q;
    assign armed_o = (state_q == PTR_ARMED);

    assert_clear_after_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PTR_ARMED && use_i) |=> (ptr_o == '0 && !armed_o));
    assert_armed_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o == (ptr_o != '0));
endmodule

// File: rtl/iaccess_reg_bank.sv
module iaccess_reg_bank
    import iaccess_pkg::*;
#(
    parameter int NREGS = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic [IDX_W-1:0]             idx_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [NREGS-1:0][DATA_W-1:0] q_o
);
    assign q_o[0] = '0;

    for (genvar i = 1; i < NREGS; i++) begin : g_reg
        logic [DATA_W-1:0] r_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                r_q <= '0;
            else if (we_i && idx_i == IDX_W'(i))
                r_q <= wdata_i;
        end
        assign q_o[i] = r_q;
    end
endmodule

// File: rtl/iaccess_top.sv
module iaccess_top
    import iaccess_pkg::*;
#(
    parameter int SER_REGS = 12,
    parameter int DMA_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_strap,
    input  logic              sel_a0,
    input  logic              sel_a1,
    input  logic              as_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int NCH = 2;

    logic              direct_q;
    logic              as_q;
    logic [5:0]        ad_lat_q;
    logic              ser_left_q;
    logic [SER_PW-1:0] ser_ptr;
    logic [DMA_PW-1:0] dma_ptr;
    logic              ser_armed, dma_armed;

    logic [SER_REGS-1:0][DATA_W-1:0] ser_q [NCH];
    logic [DMA_REGS-1:0][DATA_W-1:0] dma_q;

    // Strap capture and address strobe edge handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            direct_q <= mode_strap;
            as_q     <= 1'b1;
            ad_lat_q <= '0;
        end else begin
            as_q <= as_n;
            if (as_q && !as_n)
                ad_lat_q <= bus_data[5:0];
        end
    end

    // Access decode
    logic is_dma, chan_a, acc_wr, acc_rd, acc_any, shift_left;
    logic [IDX_W-1:0] idx;

    always_comb begin
        is_dma     = !sel_a0;
        chan_a     = sel_a0 && sel_a1;
        acc_wr     = wr_en;
        acc_rd     = rd_en && !wr_en;
        acc_any    = acc_wr || acc_rd;
        shift_left = is_dma ? dma_q[DMA_CFG][0] : ser_left_q;
        if (direct_q)
            idx = shift_left ? ad_lat_q[5:1] : ad_lat_q[4:0];
        else if (is_dma)
            idx = dma_ptr;
        else
            idx = {{(IDX_W-SER_PW){1'b0}}, ser_ptr};
    end

    logic ser_hit, dma_hit;
    assign ser_hit = idx < IDX_W'(SER_REGS);
    assign dma_hit = idx < IDX_W'(DMA_REGS);

    // Pointer machines, one per bank
    logic              ser_load, dma_load, ser_use, dma_use;
    logic [SER_PW-1:0] ser_load_val;

    assign ser_load     = !direct_q && acc_wr && !is_dma && idx == '0;
    assign dma_load     = !direct_q && acc_wr &&  is_dma && idx == '0;
    assign ser_use      = !direct_q && acc_any && !is_dma;
    assign dma_use      = !direct_q && acc_any &&  is_dma;
    assign ser_load_val = {bus_data[5:3] == CMD_PT_HIGH, bus_data[2:0]};

    iaccess_ptr_fsm #(.PW(SER_PW)) u_ser_ptr (
        .clk(clk), .rst_n(rst_n), .load_i(ser_load), .load_val_i(ser_load_val),
        .use_i(ser_use), .ptr_o(ser_ptr), .armed_o(ser_armed)
    );

    iaccess_ptr_fsm #(.PW(DMA_PW)) u_dma_ptr (
        .clk(clk), .rst_n(rst_n), .load_i(dma_load), .load_val_i(bus_data[DMA_PW-1:0]),
        .use_i(dma_use), .ptr_o(dma_ptr), .armed_o(dma_armed)
    );

    // Serial shift mode, written through register 0 in direct mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            ser_left_q <= 1'b0;
        else if (direct_q && acc_wr && !is_dma && idx == '0) begin
            if (bus_data[1:0] == 2'b01)
                ser_left_q <= 1'b1;
            else if (bus_data[1:0] == 2'b10)
                ser_left_q <= 1'b0;
        end
    end

    // Register storage
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic we_c;
        assign we_c = acc_wr && !is_dma && ser_hit && (chan_a == (c == 0));
        iaccess_reg_bank #(.NREGS(SER_REGS)) u_bank (
            .clk(clk), .rst_n(rst_n), .we_i(we_c), .idx_i(idx),
            .wdata_i(bus_data), .q_o(ser_q[c])
        );
    end

    logic dma_we;
    assign dma_we = acc_wr && is_dma && dma_hit;
    iaccess_reg_bank #(.NREGS(DMA_REGS)) u_dma_bank (
        .clk(clk), .rst_n(rst_n), .we_i(dma_we), .idx_i(idx),
        .wdata_i(bus_data), .q_o(dma_q)
    );

    // Read selection
    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (is_dma) begin
            if (idx == '0)
                rd_mux = {{(DATA_W-DMA_PW){1'b0}}, dma_ptr};
            else
                for (int i = 1; i < DMA_REGS; i++)
                    if (idx == IDX_W'(i)) rd_mux = dma_q[i];
        end else begin
            if (idx == '0)
                rd_mux = {6'b0, ser_left_q, chan_a};
            else
                for (int i = 1; i < SER_REGS; i++)
                    if (idx == IDX_W'(i)) rd_mux = chan_a ? ser_q[0][i] : ser_q[1][i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_rd;
            rd_data  <= acc_rd ? rd_mux : '0;
        end
    end

    assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rd_valid);
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> !rd_valid);
    assert_direct_no_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        direct_q |-> (!ser_armed && !dma_armed));
    assert_dma_indep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_any && sel_a0) |=> $stable(dma_ptr));
    assert_ser_indep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_any && !sel_a0) |=> $stable(ser_ptr));
    assert_unimpl_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !is_dma && !ser_hit) |=> (rd_data == '0));
endmodule

// File: tb/iaccess_top_bench.sv
module iaccess_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_strap = 1'b0;
    logic       sel_a0 = 1'b0, sel_a1 = 1'b0, as_n = 1'b1;
    logic [7:0] bus_data = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    iaccess_top u_iaccess_top (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .sel_a0(sel_a0),
        .sel_a1(sel_a1), .as_n(as_n), .bus_data(bus_data), .wr_en(wr_en),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Monitor: pops expected items as read data appears
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && rd_valid) begin
                vectors++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9: unexpected rd_valid, data %h expected none", rd_data);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if (rd_data !== e) begin
                        errors++;
                        $display("FAIL %s: rd_data %h expected %h", t, rd_data, e);
                    end
                end
            end
        end
    end

    task automatic bus_wr(input logic a0, input logic a1, input logic [7:0] d);
        @(negedge clk);
        sel_a0 = a0; sel_a1 = a1; bus_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic a0, input logic a1, input logic [7:0] e, input string t);
        @(negedge clk);
        sel_a0 = a0; sel_a1 = a1; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] ad);
        @(negedge clk);
        bus_data = ad; as_n = 1'b0;
        @(negedge clk);
        as_n = 1'b1;
    endtask

    function automatic logic [7:0] ptr_byte(input logic [3:0] idx);
        return {2'b00, idx[3] ? 3'b001 : 3'b000, idx[2:0]};
    endfunction

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; mode_strap = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mode_strap = ~strap;
        @(negedge clk);
        #1;
        vectors++;
        if (rd_valid !== 1'b0 || rd_data !== 8'h00) begin
            errors++;
            $display("FAIL R7: rd_valid/rd_data %b/%h expected 0/00", rd_valid, rd_data);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        // ---------- indirect mode ----------
        do_reset(1'b0);
        bus_rd(1, 1, 8'h01, "R10 status chA");
        bus_rd(1, 0, 8'h00, "R1 status chB");
        // R3: pointer then data, per channel
        bus_wr(1, 1, ptr_byte(4'd5)); bus_wr(1, 1, 8'hA5);
        bus_wr(1, 0, ptr_byte(4'd5)); bus_wr(1, 0, 8'h5B);
        bus_wr(1, 1, ptr_byte(4'd5)); bus_rd(1, 1, 8'hA5, "R3 chA reg5");
        bus_wr(1, 0, ptr_byte(4'd5)); bus_rd(1, 0, 8'h5B, "R1 chB reg5");
        bus_rd(1, 1, 8'h01, "R3 pointer cleared");
        // R2: point-high command
        bus_wr(1, 1, 8'h0B); bus_wr(1, 1, 8'h3C);
        bus_wr(1, 1, 8'h0B); bus_rd(1, 1, 8'h3C, "R2 point high reg11");
        bus_wr(1, 1, 8'h03); bus_rd(1, 1, 8'h00, "R2 low bits only reg3");
        // R4: DMA pointer, A1 ignored
        bus_wr(0, 0, 8'h02); bus_wr(0, 1, 8'h77);
        bus_wr(0, 1, 8'h02); bus_rd(0, 1, 8'h77, "R1 dma a1 ignored");
        // R4: serial pointer survives a full DMA exchange
        bus_wr(1, 1, ptr_byte(4'd5));
        bus_wr(0, 0, 8'h03); bus_wr(0, 0, 8'h44);
        bus_rd(1, 1, 8'hA5, "R4 serial ptr kept");
        bus_wr(0, 0, 8'h03); bus_rd(0, 0, 8'h44, "R4 dma reg3");
        bus_rd(0, 0, 8'h00, "R10 dma status");
        // R8: unimplemented registers
        bus_wr(1, 1, 8'h0D); bus_wr(1, 1, 8'h99);
        bus_wr(1, 1, 8'h0D); bus_rd(1, 1, 8'h00, "R8 serial unimpl read");
        bus_rd(1, 1, 8'h01, "R8 serial ptr cleared");
        bus_wr(0, 0, 8'h14); bus_wr(0, 0, 8'h12);
        bus_wr(0, 0, 8'h14); bus_rd(0, 0, 8'h00, "R8 dma unimpl read");
        bus_rd(0, 0, 8'h00, "R8 dma ptr cleared");
        bus_wr(1, 1, ptr_byte(4'd5)); bus_rd(1, 1, 8'hA5, "R8 no write side effect");

        // ---------- direct mode ----------
        do_reset(1'b1);
        strobe(8'h06); bus_wr(1, 1, 8'h61);
        strobe(8'h06); bus_rd(1, 1, 8'h61, "R5 right shift idx6");
        strobe(8'h0C); bus_rd(1, 1, 8'h00, "R5 right shift idx12");
        strobe(8'h00); bus_wr(1, 1, 8'h01);
        strobe(8'h00); bus_rd(1, 1, 8'h03, "R6 serial left set");
        strobe(8'h0C); bus_rd(1, 1, 8'h61, "R5 left shift idx6");
        strobe(8'h02); bus_wr(0, 0, 8'h22);
        strobe(8'h02); bus_rd(0, 0, 8'h22, "R6 dma still right");
        strobe(8'h01); bus_wr(0, 0, 8'h01);
        strobe(8'h04); bus_rd(0, 0, 8'h22, "R6 dma left idx2");
        strobe(8'h02); bus_rd(0, 0, 8'h01, "R6 dma cfg readback");
        strobe(8'h00); bus_wr(1, 1, 8'h04);
        strobe(8'h0C); bus_rd(1, 1, 8'h61, "R5 no pointer in direct");
        strobe(8'h00); bus_wr(1, 1, 8'h03);
        strobe(8'h00); bus_rd(1, 1, 8'h03, "R6 code 11 unchanged");
        strobe(8'h00); bus_wr(1, 1, 8'h02);
        strobe(8'h00); bus_rd(1, 1, 8'h01, "R6 serial right again");

        repeat (4) @(negedge clk);
        vectors++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: %0d reads unanswered, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule